// File: doc/BRIEF.md
# Splittable Two-Level Broadcast Instruction Bus

This block carries short programming messages across a rectangular grid of instruction-switch nodes. Every column of nodes shares one vertical bus segment and every row shares one horizontal bus segment. A splitter switch sits between each pair of neighbouring nodes on a segment. A closed splitter joins the two pieces of the segment. An open splitter isolates them, so different partitions of the grid can be programmed at the same time without interfering.

A message enters at a node's issue port. In its first cycle it spreads over the joined part of that node's column, and the node whose row matches the destination row captures it. In the second cycle that node rebroadcasts the message over the joined part of its row, and the node whose column matches the destination column captures it. A delivery message then appears at that node's local controller port. A toggle message instead flips one splitter next to the addressed node, one cycle later. Messages from several sources on one joined segment are resolved by a fixed priority, and the loss is flagged.

A message is a packed word `{row, col, op, payload}`, with the payload in the least significant bits. The op codes are 0 for delivery, 1 for toggling the splitter below the addressed node (between row r and r+1 of its column), 2 for toggling the splitter to its right (between column c and c+1 of its row), and 3 for no action. Node n sits at row n / COLS and column n % COLS. Vertical splitter bit c*(ROWS-1)+r lies between rows r and r+1 of column c. Horizontal splitter bit r*(COLS-1)+c lies between columns c and c+1 of row r. A splitter bit of 1 means closed (joined).

Top module: `ibus_grid`

## Requirements
- R1: After reset every splitter bit reads 0 (open), and no delivery or collision output is asserted.
- R2: A delivery message issued before clock edge E reaches its destination, if that destination is connected to it, and appears as a one-cycle pulse on that node's deliver_valid bit with the payload after edge E+1. The pulse is absent after edge E. This holds whether the message travels over zero, one or two segments.
- R3: A message never crosses an open splitter. If the destination row is not joined to the source along the source column, or the destination column is not joined to the capturing node along its row, nothing is delivered and no splitter changes.
- R4: A toggle message (op 1 or 2) that reaches its node leaves the splitter bits unchanged after edge E+1 and flips exactly the addressed splitter after edge E+2. A second toggle of the same splitter reopens it.
- R5: When two or more sources on one joined vertical segment issue in the same cycle, only the lowest-row source proceeds. The others are dropped, and that column's vert_collide bit pulses after edge E.
- R6: Sources on isolated segments issuing in the same cycle proceed independently, without any collision flag.
- R7: When two or more captured messages on one joined horizontal segment rebroadcast in the same cycle, only the lowest-column one proceeds. That row's horiz_collide bit pulses after edge E+1.
- R8: A node joined to several partitions accepts deliveries arriving from any of them.
- R9: Op 3, a vertical toggle addressed to the bottom row, and a horizontal toggle addressed to the rightmost column change no splitter and deliver nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | NODES | One issue strobe per node |
| issue_msg | input | NODES*MSG_W | Message per node, node n at bits n*MSG_W upward |
| deliver_valid | output | NODES | Delivery pulse to each node's local controller |
| deliver_payload | output | NODES*PAYLOAD_W | Delivered payload per node |
| vsplit_closed | output | COLS*(ROWS-1) | Vertical splitter states, 1 = joined |
| hsplit_closed | output | ROWS*(COLS-1) | Horizontal splitter states, 1 = joined |
| vert_collide | output | COLS | Per-column arbitration loss pulse |
| horiz_collide | output | ROWS | Per-row arbitration loss pulse |

## Verification
The assertions check properties that hold on every cycle. The splitters are all open when reset ends. No delivery appears without an issue two cycles earlier. No splitter moves without an issue three cycles earlier. A collision flag never rises unless at least two sources issued in the matching earlier cycle. Routing correctness is checked only by the bench scenarios, which track the expected splitter map. Those scenarios cover which node gets a message, whether an open splitter really blocks it, which competitor wins, and the exact cycle a splitter flips.

// File: rtl/ibus_pkg.sv
package ibus_pkg;

    localparam int unsigned GRID_ROWS = 4;
    localparam int unsigned GRID_COLS = 4;
    localparam int unsigned PAYLOAD_W = 16;

    localparam int unsigned NODES = GRID_ROWS * GRID_COLS;
    localparam int unsigned ROW_W = (GRID_ROWS > 1) ? $clog2(GRID_ROWS) : 1;
    localparam int unsigned COL_W = (GRID_COLS > 1) ? $clog2(GRID_COLS) : 1;
    localparam int unsigned VSPL  = GRID_ROWS - 1;
    localparam int unsigned HSPL  = GRID_COLS - 1;
    localparam int unsigned SPAN  = (GRID_ROWS > GRID_COLS) ? GRID_ROWS : GRID_COLS;

    typedef enum logic [1:0] {
        OP_DELIVER = 2'b00,
        OP_TOG_V   = 2'b01,
        OP_TOG_H   = 2'b10,
        OP_NONE    = 2'b11
    } ibus_op_e;

    typedef struct packed {
        logic [ROW_W-1:0]     row;
        logic [COL_W-1:0]     col;
        ibus_op_e             op;
        logic [PAYLOAD_W-1:0] payload;
    } ibus_msg_t;

    localparam int unsigned MSG_W = $bits(ibus_msg_t);

    // True when every splitter between lanes a and b is closed.
    function automatic logic seg_joined(input logic [SPAN-1:0] closed,
                                        input int a, input int b);
        int lo;
        int hi;
        logic ok;
        lo = (a < b) ? a : b;
        hi = (a < b) ? b : a;
        ok = 1'b1;
        for (int i = 0; i < int'(SPAN); i++) begin
            if (i >= lo && i < hi && !closed[i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/ibus_segment.sv
// One bus segment line: arbitrates sources per joined piece and registers
// the message at the lane whose index matches the selected address field.
module ibus_segment import ibus_pkg::*; #(
    parameter int unsigned LANES     = 4,
    parameter bit          MATCH_COL = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LANES-1:0]      src_valid,
    input  ibus_msg_t [LANES-1:0] src_msg,
    input  logic [SPAN-1:0]       closed,
    output logic [LANES-1:0]      hit_valid,
    output ibus_msg_t [LANES-1:0] hit_msg,
    output logic                  collide
);

    logic [LANES-1:0]      grant;
    logic [LANES-1:0]      nxt_valid;
    ibus_msg_t [LANES-1:0] nxt_msg;

    function automatic int key_of(input ibus_msg_t m);
        return MATCH_COL ? int'(m.col) : int'(m.row);
    endfunction

    // Fixed priority: a lower lane on the same joined piece wins.
    always_comb begin
        logic blocked;
        grant = '0;
        for (int s = 0; s < int'(LANES); s++) begin
            blocked = 1'b0;
            for (int t = 0; t < s; t++) begin
                if (src_valid[t] && seg_joined(closed, t, s)) blocked = 1'b1;
            end
            grant[s] = src_valid[s] && !blocked;
        end
    end

    always_comb begin
        nxt_valid = '0;
        nxt_msg   = '0;
        for (int r = 0; r < int'(LANES); r++) begin
            for (int s = 0; s < int'(LANES); s++) begin
                if (grant[s] && seg_joined(closed, s, r) && key_of(src_msg[s]) == r) begin
                    nxt_valid[r] = 1'b1;
                    nxt_msg[r]   = src_msg[s];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_valid <= '0;
            hit_msg   <= '0;
            collide   <= 1'b0;
        end else begin
            hit_valid <= nxt_valid;
            hit_msg   <= nxt_msg;
            collide   <= |(src_valid & ~grant);
        end
    end

endmodule

// File: rtl/ibus_splitters.sv
// Splitter state: a decoded toggle at a node flips its lower or right splitter.
module ibus_splitters import ibus_pkg::*; (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      hit_valid [NODES],
    input  ibus_msg_t                 hit_msg   [NODES],
    output logic [GRID_COLS*VSPL-1:0] vclosed,
    output logic [GRID_ROWS*HSPL-1:0] hclosed
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vclosed <= '0;
            hclosed <= '0;
        end else begin
            for (int c = 0; c < int'(GRID_COLS); c++) begin
                for (int r = 0; r < int'(VSPL); r++) begin
                    if (hit_valid[r*GRID_COLS+c] && hit_msg[r*GRID_COLS+c].op == OP_TOG_V)
                        vclosed[c*VSPL+r] <= ~vclosed[c*VSPL+r];
                end
            end
            for (int r = 0; r < int'(GRID_ROWS); r++) begin
                for (int c = 0; c < int'(HSPL); c++) begin
                    if (hit_valid[r*GRID_COLS+c] && hit_msg[r*GRID_COLS+c].op == OP_TOG_H)
                        hclosed[r*HSPL+c] <= ~hclosed[r*HSPL+c];
                end
            end
        end
    end

endmodule

// File: rtl/ibus_grid.sv
module ibus_grid import ibus_pkg::*; (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NODES-1:0]            issue_valid,
    input  logic [NODES*MSG_W-1:0]      issue_msg,
    output logic [NODES-1:0]            deliver_valid,
    output logic [NODES*PAYLOAD_W-1:0]  deliver_payload,
    output logic [GRID_COLS*VSPL-1:0]   vsplit_closed,
    output logic [GRID_ROWS*HSPL-1:0]   hsplit_closed,
    output logic [GRID_COLS-1:0]        vert_collide,
    output logic [GRID_ROWS-1:0]        horiz_collide
);

    logic      vcap_valid [NODES];
    ibus_msg_t vcap_msg   [NODES];
    logic      hcap_valid [NODES];
    ibus_msg_t hcap_msg   [NODES];

    // First level: one vertical segment per column, matched on row.
    for (genvar c = 0; c < GRID_COLS; c++) begin : g_col
        logic [GRID_ROWS-1:0]      sv;
        ibus_msg_t [GRID_ROWS-1:0] sm;
        logic [GRID_ROWS-1:0]      hv;
        ibus_msg_t [GRID_ROWS-1:0] hm;
        logic [SPAN-1:0]           cl;
        for (genvar r = 0; r < GRID_ROWS; r++) begin : g_lane
            assign sv[r] = issue_valid[r*GRID_COLS+c];
            assign sm[r] = ibus_msg_t'(issue_msg[(r*GRID_COLS+c)*MSG_W +: MSG_W]);
            assign vcap_valid[r*GRID_COLS+c] = hv[r];
            assign vcap_msg[r*GRID_COLS+c]   = hm[r];
        end
        assign cl = SPAN'(vsplit_closed[c*VSPL +: VSPL]);
        ibus_segment #(.LANES(GRID_ROWS), .MATCH_COL(1'b0)) u_vseg (
            .clk(clk), .rst(rst), .src_valid(sv), .src_msg(sm), .closed(cl),
            .hit_valid(hv), .hit_msg(hm), .collide(vert_collide[c])
        );
    end

    // Second level: one horizontal segment per row, matched on column.
    for (genvar r = 0; r < GRID_ROWS; r++) begin : g_row
        logic [GRID_COLS-1:0]      sv;
        ibus_msg_t [GRID_COLS-1:0] sm;
        logic [GRID_COLS-1:0]      hv;
        ibus_msg_t [GRID_COLS-1:0] hm;
        logic [SPAN-1:0]           cl;
        for (genvar c = 0; c < GRID_COLS; c++) begin : g_lane
            assign sv[c] = vcap_valid[r*GRID_COLS+c];
            assign sm[c] = vcap_msg[r*GRID_COLS+c];
            assign hcap_valid[r*GRID_COLS+c] = hv[c];
            assign hcap_msg[r*GRID_COLS+c]   = hm[c];
        end
        assign cl = SPAN'(hsplit_closed[r*HSPL +: HSPL]);
        ibus_segment #(.LANES(GRID_COLS), .MATCH_COL(1'b1)) u_hseg (
            .clk(clk), .rst(rst), .src_valid(sv), .src_msg(sm), .closed(cl),
            .hit_valid(hv), .hit_msg(hm), .collide(horiz_collide[r])
        );
    end

    ibus_splitters u_split (
        .clk(clk), .rst(rst), .hit_valid(hcap_valid), .hit_msg(hcap_msg),
        .vclosed(vsplit_closed), .hclosed(hsplit_closed)
    );

    always_comb begin
        for (int n = 0; n < int'(NODES); n++) begin
            deliver_valid[n] = hcap_valid[n] && (hcap_msg[n].op == OP_DELIVER);
            deliver_payload[n*PAYLOAD_W +: PAYLOAD_W] =
                deliver_valid[n] ? hcap_msg[n].payload : '0;
        end
    end

endmodule

// File: rtl/ibus_grid_checker.sv
module ibus_grid_checker import ibus_pkg::*; (
    input logic                      clk,
    input logic                      rst,
    input logic [NODES-1:0]          issue_valid,
    input logic [NODES-1:0]          deliver_valid,
    input logic [GRID_COLS*VSPL-1:0] vsplit_closed,
    input logic [GRID_ROWS*HSPL-1:0] hsplit_closed,
    input logic [GRID_COLS-1:0]      vert_collide,
    input logic [GRID_ROWS-1:0]      horiz_collide
);

    a_r1_open_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (vsplit_closed == '0 && hsplit_closed == '0 && deliver_valid == '0));

    a_r2_delivery_has_cause: assert property (@(posedge clk) disable iff (rst)
        (deliver_valid != '0) |-> ($past(issue_valid, 2) != '0));

    a_r4_split_change_has_cause: assert property (@(posedge clk) disable iff (rst)
        (vsplit_closed != $past(vsplit_closed) || hsplit_closed != $past(hsplit_closed))
        |-> ($past(issue_valid, 3) != '0));

    a_r5_vert_collide_needs_two: assert property (@(posedge clk) disable iff (rst)
        (vert_collide != '0) |-> ($countones($past(issue_valid)) >= 2));

    a_r7_horiz_collide_needs_two: assert property (@(posedge clk) disable iff (rst)
        (horiz_collide != '0) |-> ($countones($past(issue_valid, 2)) >= 2));

endmodule

bind ibus_grid ibus_grid_checker u_chk (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .deliver_valid(deliver_valid),
    .vsplit_closed(vsplit_closed), .hsplit_closed(hsplit_closed),
    .vert_collide(vert_collide), .horiz_collide(horiz_collide)
);

// File: tb/ibus_grid_bench.sv
`timescale 1ns/1ps
module ibus_grid_bench;
    import ibus_pkg::*;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [NODES-1:0]           issue_valid = '0;
    logic [NODES*MSG_W-1:0]     issue_msg = '0;
    logic [NODES-1:0]           deliver_valid;
    logic [NODES*PAYLOAD_W-1:0] deliver_payload;
    logic [GRID_COLS*VSPL-1:0]  vsplit_closed;
    logic [GRID_ROWS*HSPL-1:0]  hsplit_closed;
    logic [GRID_COLS-1:0]       vert_collide;
    logic [GRID_ROWS-1:0]       horiz_collide;

    logic [GRID_COLS*VSPL-1:0]  exp_v = '0;
    logic [GRID_ROWS*HSPL-1:0]  exp_h = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ibus_grid u_ibus_grid (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_msg(issue_msg),
        .deliver_valid(deliver_valid), .deliver_payload(deliver_payload),
        .vsplit_closed(vsplit_closed), .hsplit_closed(hsplit_closed),
        .vert_collide(vert_collide), .horiz_collide(horiz_collide)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int nd(input int r, input int c);
        return r * GRID_COLS + c;
    endfunction

    // Message word {row, col, op, payload}, payload in the low bits.
    function automatic logic [MSG_W-1:0] mk(input int r, input int c,
                                            input logic [1:0] op, input logic [PAYLOAD_W-1:0] pl);
        return {ROW_W'(r), COL_W'(c), op, pl};
    endfunction

    function automatic logic [NODES-1:0] bit_at(input int n);
        logic [NODES-1:0] v;
        v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    function automatic logic [PAYLOAD_W-1:0] pay(input int n);
        return deliver_payload[n*PAYLOAD_W +: PAYLOAD_W];
    endfunction

    task automatic drive(input int s, input logic [MSG_W-1:0] m);
        issue_valid[s] = 1'b1;
        issue_msg[s*MSG_W +: MSG_W] = m;
    endtask

    task automatic idle();
        issue_valid = '0;
        issue_msg = '0;
    endtask

    // One message; returns at the falling edge after the third rising edge.
    task automatic xfer(input string req, input int src, input int dr, input int dc,
                        input logic [1:0] op, input logic [PAYLOAD_W-1:0] pl, input bit reach);
        logic [GRID_COLS*VSPL-1:0] old_v;
        logic [GRID_ROWS*HSPL-1:0] old_h;
        logic [NODES-1:0] exp_dv;
        old_v = exp_v;
        old_h = exp_h;
        @(negedge clk); drive(src, mk(dr, dc, op, pl));
        @(negedge clk); idle();
        chk(deliver_valid == '0, req, "delivery after one edge", 64'(deliver_valid), 0);
        @(negedge clk);
        exp_dv = (reach && op == OP_DELIVER) ? bit_at(nd(dr, dc)) : '0;
        chk(deliver_valid == exp_dv, req, "delivery after two edges", 64'(deliver_valid), 64'(exp_dv));
        if (exp_dv != '0)
            chk(pay(nd(dr, dc)) == pl, req, "payload", 64'(pay(nd(dr, dc))), 64'(pl));
        chk(vsplit_closed == old_v && hsplit_closed == old_h, req, "splitters before apply",
            {32'(vsplit_closed), 32'(hsplit_closed)}, {32'(old_v), 32'(old_h)});
        if (reach && op == OP_TOG_V && dr < int'(VSPL)) exp_v[dc*VSPL+dr] = ~exp_v[dc*VSPL+dr];
        if (reach && op == OP_TOG_H && dc < int'(HSPL)) exp_h[dr*HSPL+dc] = ~exp_h[dr*HSPL+dc];
        @(negedge clk);
        chk(vsplit_closed == exp_v && hsplit_closed == exp_h, req, "splitters after apply",
            {32'(vsplit_closed), 32'(hsplit_closed)}, {32'(exp_v), 32'(exp_h)});
        chk(deliver_valid == '0, req, "delivery is a single pulse", 64'(deliver_valid), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(vsplit_closed == '0 && hsplit_closed == '0, "R1", "splitters open",
            {32'(vsplit_closed), 32'(hsplit_closed)}, 0);
        chk(deliver_valid == '0 && vert_collide == '0 && horiz_collide == '0, "R1", "outputs idle",
            {32'(deliver_valid), 16'(vert_collide), 16'(horiz_collide)}, 0);
    endtask

    task automatic t_local_and_isolation();
        xfer("R2", 0, 0, 0, OP_DELIVER, 16'hA1A1, 1'b1);   // same node, zero hops
        xfer("R3", 0, 2, 0, OP_DELIVER, 16'hBEEF, 1'b0);   // blocked by open splitter
    endtask

    task automatic t_toggle_and_reach();
        xfer("R4", 0, 0, 0, OP_TOG_V, 16'h0, 1'b1);        // join rows 0-1 in column 0
        xfer("R4", 0, 1, 0, OP_TOG_V, 16'h0, 1'b1);        // join rows 1-2 in column 0
        xfer("R2", 0, 2, 0, OP_DELIVER, 16'h1234, 1'b1);   // one vertical hop
        xfer("R4", 0, 2, 0, OP_TOG_H, 16'h0, 1'b1);        // join columns 0-1 in row 2
        xfer("R2", 0, 2, 1, OP_DELIVER, 16'h5678, 1'b1);   // vertical then horizontal
    endtask

    task automatic t_shared_node();
        xfer("R8", nd(2, 1), 2, 0, OP_DELIVER, 16'h0C0C, 1'b1);  // from column 1 partition
        xfer("R8", 0, 2, 0, OP_DELIVER, 16'h0D0D, 1'b1);         // from column 0 partition
    endtask

    task automatic t_reopen();
        xfer("R4", 0, 2, 0, OP_TOG_H, 16'h0, 1'b1);        // second toggle opens it
        xfer("R3", 0, 2, 1, OP_DELIVER, 16'h9999, 1'b0);
    endtask

    task automatic t_boundary();
        xfer("R9", nd(3, 3), 3, 3, OP_TOG_V, 16'h0, 1'b1);
        xfer("R9", nd(3, 3), 3, 3, OP_TOG_H, 16'h0, 1'b1);
        xfer("R9", nd(3, 3), 3, 3, OP_NONE, 16'h7777, 1'b1);
    endtask

    task automatic t_vert_collision();
        @(negedge clk);
        drive(nd(0, 0), mk(0, 0, OP_DELIVER, 16'h1111));
        drive(nd(1, 0), mk(1, 0, OP_DELIVER, 16'h2222));
        @(negedge clk); idle();
        chk(vert_collide == 4'b0001, "R5", "column 0 collision flag", 64'(vert_collide), 1);
        @(negedge clk);
        chk(deliver_valid == bit_at(0), "R5", "lowest row wins", 64'(deliver_valid), 64'(bit_at(0)));
        chk(pay(0) == 16'h1111, "R5", "winner payload", 64'(pay(0)), 64'h1111);
        chk(vert_collide == '0, "R5", "flag is a pulse", 64'(vert_collide), 0);
        @(negedge clk);
    endtask

    task automatic t_parallel();
        @(negedge clk);
        drive(nd(0, 2), mk(0, 2, OP_DELIVER, 16'h2A2A));
        drive(nd(0, 3), mk(0, 3, OP_DELIVER, 16'h3B3B));
        @(negedge clk); idle();
        chk(vert_collide == '0, "R6", "no vertical collision", 64'(vert_collide), 0);
        @(negedge clk);
        chk(deliver_valid == (bit_at(2) | bit_at(3)), "R6", "both delivered",
            64'(deliver_valid), 64'(bit_at(2) | bit_at(3)));
        chk(pay(2) == 16'h2A2A && pay(3) == 16'h3B3B, "R6", "both payloads",
            {32'(pay(2)), 32'(pay(3))}, 64'h00002A2A00003B3B);
        chk(horiz_collide == '0, "R6", "no horizontal collision", 64'(horiz_collide), 0);
        @(negedge clk);
    endtask

    task automatic t_horiz_collision();
        xfer("R7", nd(0, 2), 0, 2, OP_TOG_H, 16'h0, 1'b1);   // join columns 2-3 in row 0
        @(negedge clk);
        drive(nd(0, 2), mk(0, 3, OP_DELIVER, 16'h3333));
        drive(nd(0, 3), mk(0, 2, OP_DELIVER, 16'h4444));
        @(negedge clk); idle();
        chk(vert_collide == '0, "R7", "separate columns", 64'(vert_collide), 0);
        @(negedge clk);
        chk(horiz_collide == 4'b0001, "R7", "row 0 collision flag", 64'(horiz_collide), 1);
        chk(deliver_valid == bit_at(3), "R7", "lowest column wins", 64'(deliver_valid), 64'(bit_at(3)));
        chk(pay(3) == 16'h3333, "R7", "winner payload", 64'(pay(3)), 64'h3333);
        @(negedge clk);
        chk(horiz_collide == '0, "R7", "flag is a pulse", 64'(horiz_collide), 0);
    endtask

    initial begin
        t_reset();
        t_local_and_isolation();
        t_toggle_and_reach();
        t_shared_node();
        t_reopen();
        t_boundary();
        t_vert_collision();
        t_parallel();
        t_horiz_collision();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule